// File: doc/BRIEF.md
# Dual-Path Latched/Registered Bus Transceiver

This block moves an 18-bit word between two ports in both directions at once. The A-to-B path and the B-to-A path each have their own storage element and their own four controls: an output enable, a latch enable, a transfer clock and a clock enable. The output enable and the clock enable are both active-low. A path runs in one of three modes. In transparent mode the output follows the input. In latched mode the storage holds its word. In clocked mode the storage takes a new word on a rising edge of the transfer clock.

Each output is a data vector plus a drive flag, so no tri-state pads are needed. A parent that connects to a real pad uses the flag as the pad enable. The block works on a synchronous system clock. It samples each transfer clock on that clock and treats a change from 0 to 1 between two consecutive samples as a rising edge. Because of this sampling, each transfer clock must stay in each level for at least one system clock cycle. The two paths share nothing except the system clock and the reset.

Top module: `dual_path_xcvr`

## Requirements
- R1: While a path's latch enable is 1 and its output is driven, the output data equals that path's input in the same cycle, with no register in between.
- R2: While the latch enable is 0 and the active-low clock enable is 0, a transfer-clock sample of 1 that follows a sample of 0 stores the input present at that system clock edge. The new word appears at the output after that edge.
- R3: While the latch enable is 0, the stored word does not change when the transfer clock is sampled low, or when it stays high without a new rising edge.
- R4: While the clock enable is 1, a transfer-clock rising edge leaves the stored word unchanged.
- R5: While the active-low output enable is 1, the drive flag is 0 and the output data is all zeros, whatever the other controls do.
- R6: While the output is driven and the latch enable is 0, the output data equals the stored word.
- R7: The B-to-A path follows R1 to R6 with its own four controls. Nothing done on one path changes the output or the stored word of the other path.
- R8: After reset both stored words are zero. A path whose output is enabled but not transparent then drives zero.
- R9: When the latch enable falls, the path keeps the input word sampled at the last system clock edge at which the latch enable was still 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| a_in | input | 18 | Data arriving at port A |
| a_out | output | 18 | Data driven onto port A (B-to-A path) |
| a_drv | output | 1 | Drive flag for port A |
| b_in | input | 18 | Data arriving at port B |
| b_out | output | 18 | Data driven onto port B (A-to-B path) |
| b_drv | output | 1 | Drive flag for port B |
| oe_ab_n | input | 1 | A-to-B output enable, active-low |
| le_ab | input | 1 | A-to-B latch enable |
| tclk_ab | input | 1 | A-to-B transfer clock |
| ce_ab_n | input | 1 | A-to-B clock enable, active-low |
| oe_ba_n | input | 1 | B-to-A output enable, active-low |
| le_ba | input | 1 | B-to-A latch enable |
| tclk_ba | input | 1 | B-to-A transfer clock |
| ce_ba_n | input | 1 | B-to-A clock enable, active-low |

## Verification
The assertions assume that every control and data input changes only between system clock edges. They also assume that each transfer clock stays in each level for at least one system clock cycle, so that the edge detector sees every level. The latching assertion further assumes that the input word does not change between the last sampling edge and the fall of the latch enable. The stimulus drives every input on the falling edge of the system clock and holds each transfer-clock level for at least a full cycle. It changes the latch enable only at a point where the input word already held at the preceding edge is the word that should be latched.

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_drv,
  input  logic         oe_ab_n,
  input  logic         le_ab,
  input  logic         tclk_ab,
  input  logic         ce_ab_n,
  input  logic         oe_ba_n,
  input  logic         le_ba,
  input  logic         tclk_ba,
  input  logic         ce_ba_n
);

  logic [W-1:0] st_ab, st_ba;
  logic         tclk_ab_q, tclk_ba_q;
  logic         cap_ab, cap_ba;

  assign cap_ab = !le_ab && !ce_ab_n && tclk_ab && !tclk_ab_q;
  assign cap_ba = !le_ba && !ce_ba_n && tclk_ba && !tclk_ba_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tclk_ab_q <= 1'b0;
      st_ab     <= '0;
    end else begin
      tclk_ab_q <= tclk_ab;
      if (le_ab || cap_ab) st_ab <= a_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tclk_ba_q <= 1'b0;
      st_ba     <= '0;
    end else begin
      tclk_ba_q <= tclk_ba;
      if (le_ba || cap_ba) st_ba <= b_in;
    end
  end

  assign b_drv = !oe_ab_n;
  assign a_drv = !oe_ba_n;
  assign b_out = oe_ab_n ? '0 : (le_ab ? a_in : st_ab);
  assign a_out = oe_ba_n ? '0 : (le_ba ? b_in : st_ba);

  p_transp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (le_ab && b_drv) |-> (b_out == a_in));
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ab && !ce_ab_n && tclk_ab && !tclk_ab_q) |=> (st_ab == $past(a_in)));
  p_hold_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ab && !tclk_ab) |=> (st_ab == $past(st_ab)));
  p_ce_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ab && ce_ab_n) |=> (st_ab == $past(st_ab)));
  p_off_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !b_drv |-> (b_out == '0));
  p_stored_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (b_drv && !le_ab) |-> (b_out == st_ab));
  p_transp_ba_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (le_ba && a_drv) |-> (a_out == b_in));
  p_capture_ba_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ba && !ce_ba_n && tclk_ba && !tclk_ba_q) |=> (st_ba == $past(b_in)));
  p_off_ba_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !a_drv |-> (a_out == '0));
  p_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(le_ab) |-> (st_ab == $past(a_in)));

endmodule

// File: tb/sim_dual_path_xcvr.sv
`timescale 1ns/1ps
module sim_dual_path_xcvr;
  localparam int W = 18;

  typedef struct {
    logic [W-1:0] eb;
    logic         ebd;
    logic [W-1:0] ea;
    logic         ead;
    string        tag;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_drv, b_drv;
  logic oe_ab_n = 1'b1, le_ab = 1'b0, tclk_ab = 1'b0, ce_ab_n = 1'b1;
  logic oe_ba_n = 1'b1, le_ba = 1'b0, tclk_ba = 1'b0, ce_ba_n = 1'b1;

  int checks = 0, fails = 0;
  bit done = 0;
  item_t q[$];

  always #2.5 clk = ~clk;

  dual_path_xcvr #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
    .oe_ab_n(oe_ab_n), .le_ab(le_ab), .tclk_ab(tclk_ab), .ce_ab_n(ce_ab_n),
    .oe_ba_n(oe_ba_n), .le_ba(le_ba), .tclk_ba(tclk_ba), .ce_ba_n(ce_ba_n)
  );

  task automatic expect_now(input logic [W-1:0] eb, input logic ebd,
                            input logic [W-1:0] ea, input logic ead,
                            input string tag);
    item_t it;
    @(posedge clk);
    #1;
    it.eb = eb; it.ebd = ebd; it.ea = ea; it.ead = ead; it.tag = tag;
    q.push_back(it);
  endtask

  always begin
    @(posedge clk);
    #2;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (b_out !== it.eb || b_drv !== it.ebd || a_out !== it.ea || a_drv !== it.ead) begin
        fails++;
        $display("FAIL %s: b=%h/%b a=%h/%b expected b=%h/%b a=%h/%b", it.tag,
                 b_out, b_drv, a_out, a_drv, it.eb, it.ebd, it.ea, it.ead);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_now('0, 0, '0, 0, "R8 reset outputs idle");
    @(negedge clk); oe_ab_n = 0;
    expect_now('0, 1, '0, 0, "R8 stored zero driven");
    @(negedge clk); le_ab = 1; a_in = 18'h15A5A;
    expect_now(18'h15A5A, 1, '0, 0, "R1 transparent");
    @(negedge clk); a_in = 18'h2AAAA;
    expect_now(18'h2AAAA, 1, '0, 0, "R1 follows input");
    @(negedge clk); le_ab = 0;
    expect_now(18'h2AAAA, 1, '0, 0, "R9 latch closes on last word");
    @(negedge clk); a_in = 18'h3FFFF;
    expect_now(18'h2AAAA, 1, '0, 0, "R6 stored word driven");
    @(negedge clk); ce_ab_n = 0; tclk_ab = 1;
    expect_now(18'h3FFFF, 1, '0, 0, "R2 rising edge captures");
    @(negedge clk); a_in = 18'h00F0F;
    expect_now(18'h3FFFF, 1, '0, 0, "R3 clock held high no capture");
    @(negedge clk); tclk_ab = 0; a_in = 18'h01111;
    expect_now(18'h3FFFF, 1, '0, 0, "R3 clock low holds");
    @(negedge clk); ce_ab_n = 1; tclk_ab = 1; a_in = 18'h01234;
    expect_now(18'h3FFFF, 1, '0, 0, "R4 disabled clock ignored");
    @(negedge clk); tclk_ab = 0;
    expect_now(18'h3FFFF, 1, '0, 0, "R4 still held");
    @(negedge clk); ce_ab_n = 0; tclk_ab = 1;
    expect_now(18'h01234, 1, '0, 0, "R2 capture after re-enable");
    @(negedge clk); tclk_ab = 0; oe_ab_n = 1;
    expect_now('0, 0, '0, 0, "R5 output off");
    @(negedge clk); le_ab = 1;
    expect_now('0, 0, '0, 0, "R5 off while transparent");
    @(negedge clk); oe_ab_n = 0;
    expect_now(18'h01234, 1, '0, 0, "R1 re-enabled transparent");
    @(negedge clk); le_ab = 0; ce_ab_n = 1;
    expect_now(18'h01234, 1, '0, 0, "R9 latched before B-to-A phase");
    @(negedge clk); oe_ba_n = 0; le_ba = 1; b_in = 18'h0ABCD; a_in = 18'h3FFFF;
    expect_now(18'h01234, 1, 18'h0ABCD, 1, "R7 B-to-A transparent");
    @(negedge clk); le_ba = 0; ce_ba_n = 0;
    expect_now(18'h01234, 1, 18'h0ABCD, 1, "R7 B-to-A latched");
    @(negedge clk); b_in = 18'h12345; tclk_ba = 1;
    expect_now(18'h01234, 1, 18'h12345, 1, "R7 B-to-A capture");
    @(negedge clk); tclk_ba = 0; b_in = '0;
    expect_now(18'h01234, 1, 18'h12345, 1, "R7 B-to-A hold");
    @(negedge clk); ce_ba_n = 1; tclk_ba = 1; b_in = 18'h3C3C3;
    expect_now(18'h01234, 1, 18'h12345, 1, "R7 B-to-A clock enable");
    @(negedge clk); tclk_ba = 0; tclk_ab = 1; ce_ab_n = 0; a_in = 18'h05555;
    expect_now(18'h05555, 1, 18'h12345, 1, "R7 A-to-B capture leaves B-to-A");
    @(negedge clk); tclk_ab = 0; oe_ba_n = 1;
    expect_now(18'h05555, 1, '0, 0, "R7 B-to-A output off");
    repeat (3) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule